// File: doc/BRIEF.md
# Sector Erase Collection Window

This block governs the start of a sector erase in a flash-style memory controller. The command decoder sends it a one-cycle pulse for each sector erase request, together with a sector index. The block gathers the requested sectors into a selection mask and runs an acceptance window measured in clock cycles. While the window is open, more sectors may be added, and each one that is added restarts the window from its full length. When the window runs out, the block raises the timer status bit, issues a one-cycle erase-start pulse and locks out every later command except suspend and resume. This lockout lasts until the external erase engine reports completion.

A chip erase request does not use the window. It starts the erase at once with every sector selected. During the erase, a suspend request raises a suspended flag and keeps the mask, and a resume request lowers the flag again. The completion input has no effect while the erase is suspended. Completion clears the mask and returns the block to idle, where the status bit reads 0. The number of sectors must be a power of two.

Top module: `sea_accum_timer`

## Requirements
- R1: While reset is high, and in the cycle after it is released, busy, timer_bit, erase_go, suspended and every bit of sel_mask are 0. A reset in the middle of a collection also clears them.
- R2: A sector command in idle takes effect on the next clock edge: busy goes to 1, bit sec_idx of sel_mask goes to 1 and timer_bit stays at 0.
- R3: While the window is open, timer_bit stays at 0 and each further sector command ORs its bit into sel_mask.
- R4: The window closes WIN_CYC clock edges after the last accepted sector command. A command accepted on the last edge before expiry restarts the full window. On the closing edge, timer_bit goes to 1 and erase_go is 1 for exactly that one cycle.
- R5: Once timer_bit is 1, sector and chip commands have no effect on sel_mask, busy or timer_bit.
- R6: A sector command sampled on the same edge on which the window expires is ignored, and its bit does not enter sel_mask.
- R7: A chip command in idle sets sel_mask to all ones, timer_bit to 1 and busy to 1 on the next edge, with a one-cycle erase_go. No window is run.
- R8: During an erase, susp_cmd sets suspended and keeps sel_mask. While suspended, resume_cmd clears suspended.
- R9: erase_done during an unsuspended erase returns the block to idle on the next edge, with busy, timer_bit and sel_mask all 0. erase_done while suspended is ignored.
- R10: Suspend and resume commands have no effect outside an erase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_cmd | input | 1 | One-cycle sector erase request |
| sec_idx | input | IDXW | Sector index for sec_cmd |
| chip_cmd | input | 1 | One-cycle whole-array erase request |
| susp_cmd | input | 1 | Erase suspend request |
| resume_cmd | input | 1 | Erase resume request |
| erase_done | input | 1 | Completion from the external erase engine |
| sel_mask | output | NSEC | Accumulated sector selection |
| timer_bit | output | 1 | 0 while idle or collecting, 1 once the erase has begun |
| erase_go | output | 1 | One-cycle pulse when the erase starts |
| busy | output | 1 | High from the first accepted command until completion |
| suspended | output | 1 | Erase is held in suspend |

## Verification
The bench targets the edge on which the window expires. A design that lets a sector command win on that edge would add the late bit to the mask, and a design whose counter is off by one would raise timer_bit one cycle early or late. A restart on the final open cycle is measured so that a window that fails to reload to its full length is caught. The bench also checks that completion is ignored while suspended: a design that honours it would drop busy and the mask while the erase is still parked. Lockout is probed with sector and chip commands after expiry, because a leaky design would either grow the mask or fill it with ones.

// File: rtl/sea_pkg.sv
package sea_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COLLECT = 2'd1,
    ST_ERASE   = 2'd2
  } sea_state_e;
endpackage

// File: rtl/sea_window.sv
// Restartable down-counter for the sector acceptance window.
module sea_window #(
  parameter int WIN_CYC = 5000
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic run,
  output logic expired
);
  localparam int CW = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(WIN_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= RELOAD;
    end else if (run && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = run && (cnt_q == '0);
endmodule

// File: rtl/sea_mask.sv
// Sector selection register: OR-in one bit, fill all, or clear.
module sea_mask #(
  parameter int NSEC = 16,
  parameter int IDXW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            set_one,
  input  logic [IDXW-1:0] idx,
  input  logic            set_all,
  input  logic            clr,
  output logic [NSEC-1:0] mask
);
  for (genvar i = 0; i < NSEC; i++) begin : g_bit
    logic hit;
    assign hit = set_all || (set_one && (idx == IDXW'(i)));
    always_ff @(posedge clk) begin
      if (rst || clr) begin
        mask[i] <= 1'b0;
      end else if (hit) begin
        mask[i] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sea_ctrl.sv
// Collection / erase state machine.
module sea_ctrl
  import sea_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic sec_cmd,
  input  logic chip_cmd,
  input  logic susp_cmd,
  input  logic resume_cmd,
  input  logic erase_done,
  input  logic expired,
  output logic win_load,
  output logic win_run,
  output logic m_set_one,
  output logic m_set_all,
  output logic m_clr,
  output logic busy,
  output logic timer_bit,
  output logic erase_go,
  output logic suspended
);
  sea_state_e state_q, state_d;
  logic go_q, go_d;
  logic susp_q, susp_d;

  always_comb begin
    state_d   = state_q;
    go_d      = 1'b0;
    susp_d    = susp_q;
    win_load  = 1'b0;
    m_set_one = 1'b0;
    m_set_all = 1'b0;
    m_clr     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (chip_cmd) begin
          state_d   = ST_ERASE;
          m_set_all = 1'b1;
          go_d      = 1'b1;
        end else if (sec_cmd) begin
          state_d   = ST_COLLECT;
          m_set_one = 1'b1;
          win_load  = 1'b1;
        end
      end
      ST_COLLECT: begin
        if (chip_cmd) begin
          state_d   = ST_ERASE;
          m_set_all = 1'b1;
          go_d      = 1'b1;
        end else if (expired) begin
          state_d = ST_ERASE;
          go_d    = 1'b1;
        end else if (sec_cmd) begin
          m_set_one = 1'b1;
          win_load  = 1'b1;
        end
      end
      ST_ERASE: begin
        if (susp_q) begin
          if (resume_cmd) susp_d = 1'b0;
        end else if (erase_done) begin
          state_d = ST_IDLE;
          m_clr   = 1'b1;
        end else if (susp_cmd) begin
          susp_d = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      go_q    <= 1'b0;
      susp_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      go_q    <= go_d;
      susp_q  <= susp_d;
    end
  end

  assign win_run   = (state_q == ST_COLLECT);
  assign busy      = (state_q != ST_IDLE);
  assign timer_bit = (state_q == ST_ERASE);
  assign erase_go  = go_q;
  assign suspended = susp_q;
endmodule

// File: rtl/sea_accum_timer.sv
// Top: sector erase collection window with chip-erase bypass.
module sea_accum_timer #(
  parameter int NSEC    = 16,
  parameter int WIN_CYC = 5000,
  localparam int IDXW   = (NSEC > 1) ? $clog2(NSEC) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sec_cmd,
  input  logic [IDXW-1:0] sec_idx,
  input  logic            chip_cmd,
  input  logic            susp_cmd,
  input  logic            resume_cmd,
  input  logic            erase_done,
  output logic [NSEC-1:0] sel_mask,
  output logic            timer_bit,
  output logic            erase_go,
  output logic            busy,
  output logic            suspended
);
  logic win_load, win_run, expired;
  logic m_set_one, m_set_all, m_clr;

  sea_window #(.WIN_CYC(WIN_CYC)) u_win (
    .clk(clk), .rst(rst), .load(win_load), .run(win_run), .expired(expired)
  );

  sea_mask #(.NSEC(NSEC), .IDXW(IDXW)) u_mask (
    .clk(clk), .rst(rst), .set_one(m_set_one), .idx(sec_idx),
    .set_all(m_set_all), .clr(m_clr), .mask(sel_mask)
  );

  sea_ctrl u_ctrl (
    .clk(clk), .rst(rst), .sec_cmd(sec_cmd), .chip_cmd(chip_cmd),
    .susp_cmd(susp_cmd), .resume_cmd(resume_cmd), .erase_done(erase_done),
    .expired(expired), .win_load(win_load), .win_run(win_run),
    .m_set_one(m_set_one), .m_set_all(m_set_all), .m_clr(m_clr),
    .busy(busy), .timer_bit(timer_bit), .erase_go(erase_go),
    .suspended(suspended)
  );
endmodule

// File: rtl/sea_accum_timer_chk.sv
module sea_accum_timer_chk #(
  parameter int NSEC = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            erase_done,
  input logic            resume_cmd,
  input logic [NSEC-1:0] sel_mask,
  input logic            timer_bit,
  input logic            erase_go,
  input logic            busy,
  input logic            suspended
);
  // R4
  go_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    erase_go |=> !erase_go);

  // R4
  dq_rise_with_go_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(timer_bit) |-> erase_go);

  // R5
  locked_mask_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (timer_bit && !(erase_done && !suspended)) |=> (timer_bit && $stable(sel_mask)));

  // R8
  suspend_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (suspended && !resume_cmd) |=> suspended);

  // R10
  suspend_only_in_erase_chk: assert property (@(posedge clk) disable iff (rst)
    suspended |-> timer_bit);

  // R9
  idle_clean_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (sel_mask == '0 && !timer_bit && !erase_go));
endmodule

bind sea_accum_timer sea_accum_timer_chk #(.NSEC(NSEC)) u_chk (
  .clk(clk), .rst(rst), .erase_done(erase_done), .resume_cmd(resume_cmd),
  .sel_mask(sel_mask), .timer_bit(timer_bit), .erase_go(erase_go),
  .busy(busy), .suspended(suspended)
);

// File: tb/sea_accum_timer_bench.sv
module sea_accum_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NSEC = 8;
  localparam int WIN  = 8;
  localparam int NV   = 26;

  // nibbles: req | {sec,idx} | {chip,susp,res,done} | {busy,dq3,go,susp} | mask
  localparam logic [31:0] VEC [NV] = '{
    32'h00_2A0804, // R2 sector 2 opens window
    32'h00_300804, // R3
    32'h00_300804, // R3
    32'h00_3D0824, // R3 sector 5 added, restart
    32'h00_400824, // R4 counting
    32'h00_400824,
    32'h00_400824,
    32'h00_400824,
    32'h00_400824,
    32'h00_400824,
    32'h00_400824,
    32'h00_680E24, // R6 sector 0 on expiry edge ignored
    32'h00_590C24, // R5 sector 1 ignored
    32'h00_508C24, // R5 chip ignored
    32'h00_804D24, // R8 suspend
    32'h00_901D24, // R9 done ignored while suspended
    32'h00_802C24, // R8 resume
    32'h00_901000, // R9 done
    32'h00_A04000, // R10 suspend in idle
    32'h00_A02000, // R10 resume in idle
    32'h00_708EFF, // R7 chip erase
    32'h00_700CFF, // R7
    32'h00_901000, // R9
    32'h00_000000,
    32'h00_000000,
    32'h00_000000
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sec_cmd = 1'b0, chip_cmd = 1'b0, susp_cmd = 1'b0, resume_cmd = 1'b0, erase_done = 1'b0;
  logic [2:0] sec_idx = '0;
  logic [NSEC-1:0] sel_mask;
  logic timer_bit, erase_go, busy, suspended;
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  sea_accum_timer #(.NSEC(NSEC), .WIN_CYC(WIN)) u_sea_accum_timer (
    .clk(clk), .rst(rst), .sec_cmd(sec_cmd), .sec_idx(sec_idx),
    .chip_cmd(chip_cmd), .susp_cmd(susp_cmd), .resume_cmd(resume_cmd),
    .erase_done(erase_done), .sel_mask(sel_mask), .timer_bit(timer_bit),
    .erase_go(erase_go), .busy(busy), .suspended(suspended)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++;
        $display("FAIL watchdog R4 act=%0d exp<20000", cycles);
        summary();
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act={busy,dq3,go,susp,mask}=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic s, input logic [2:0] i, input logic c,
                       input logic sp, input logic rs, input logic d);
    sec_cmd = s; sec_idx = i; chip_cmd = c;
    susp_cmd = sp; resume_cmd = rs; erase_done = d;
  endtask

  function automatic logic [11:0] outs();
    return {busy, timer_bit, erase_go, suspended, sel_mask};
  endfunction

  initial begin
    int n;
    #1;
    step();
    chk("R1 in reset", outs(), 12'h000);
    step();
    rst = 1'b0;
    step();
    chk("R1 after release", outs(), 12'h000);

    for (int v = 0; v < NV - 3; v++) begin
      drive(VEC[v][19], VEC[v][18:16], VEC[v][15], VEC[v][14], VEC[v][13], VEC[v][12]);
      step();
      chk($sformatf("R%0d vec %0d", VEC[v][23:20], v), outs(), VEC[v][11:0]);
    end
    drive(0, 0, 0, 0, 0, 0);

    // R4: window length measured from the opening command
    drive(1, 3'd7, 0, 0, 0, 0);
    step();
    drive(0, 0, 0, 0, 0, 0);
    n = 0;
    while (!timer_bit && n < 100) begin
      step();
      n++;
    end
    chk("R4 window length", 12'(n), 12'(WIN));
    chk("R4 go on expiry", outs(), 12'hE80);
    drive(0, 0, 0, 0, 0, 1);
    step();
    drive(0, 0, 0, 0, 0, 0);

    // R4: restart on the last open edge gives a full fresh window
    drive(1, 3'd1, 0, 0, 0, 0);
    step();
    drive(0, 0, 0, 0, 0, 0);
    for (int k = 0; k < WIN - 2; k++) step();
    drive(1, 3'd6, 0, 0, 0, 0);
    step();
    drive(0, 0, 0, 0, 0, 0);
    for (int k = 0; k < WIN - 1; k++) step();
    chk("R4 still open before restarted expiry", outs(), 12'h842);
    step();
    chk("R4 restarted expiry", outs(), 12'hE42);
    drive(0, 0, 0, 0, 0, 1);
    step();
    drive(0, 0, 0, 0, 0, 0);

    // R1: reset during collection clears everything
    drive(1, 3'd4, 0, 0, 0, 0);
    step();
    drive(0, 0, 0, 0, 0, 0);
    chk("R2 sector 4 opens", outs(), 12'h810);
    rst = 1'b1;
    step();
    rst = 1'b0;
    step();
    chk("R1 mid-collect reset", outs(), 12'h000);

    // R10: resume during collection has no effect
    drive(1, 3'd3, 0, 0, 0, 0);
    step();
    drive(0, 0, 0, 1, 1, 0);
    step();
    drive(0, 0, 0, 0, 0, 0);
    chk("R10 susp/resume while collecting", outs(), 12'h808);

    summary();
  end
endmodule